// File: doc/BRIEF.md
# Two-Batch Minimum SAD Selector

This block picks the best block-matching candidate of a motion search. Each candidate's sum of absolute differences (SAD) arrives in one of two batches, up to 64 SADs per batch, each batch holding half of the spread candidates. A batch enters in one cycle. A pipelined comparison tree reduces it to its lowest SAD and the candidate index of that SAD, always with the same latency. Lanes that are switched off by a mask count as the largest possible SAD, so any batch size from 1 to 64 takes the same path and the same number of cycles.

The best SAD of the first half is kept in a held-best register, which is cleared at the start of every block. When the second half leaves the tree, its best is compared with the held value and with the diamond-search result that arrives on separate inputs. The lowest of the three becomes the final motion vector. The output shows whether the diamond search or a spread candidate won. A spread winner's index is zero-extended into the motion-vector field.

Top module: `min_sad_select`

## Requirements
- R1: After reset, `batchDone`, `finalValid`, `batchSad`, `batchIdx`, `finalSad`, `finalFromDiamond` and `finalMv` are all zero.
- R2: `batchDone` is high in the cycle that follows the 7th rising edge counted from the edge that samples `batchValid`, and is low otherwise. A batch may be presented on every cycle.
- R3: `batchSad` is the lowest SAD among the lanes whose `candMask` bit is set. `batchIdx` bits 5:0 hold that lane number and bit 6 holds `batchSecond` of that batch.
- R4: When several lanes share the lowest SAD, the lane with the lowest number is reported.
- R5: A lane whose mask bit is clear is treated as SAD 65535 (all ones). With every lane masked the result is SAD 65535, lane 0.
- R6: When a first-half batch completes, the held best is replaced only if the batch SAD is strictly lower. `clearBest` sets the held best to 65535 and lane 0 at the next edge, and it takes priority over a first-half load at that same edge.
- R7: When a second-half batch completes, `finalValid` pulses together with `batchDone`. `finalSad` is the lowest of the held best, the second-half best and `dsSad`. `finalMv` is `dsMv` when the diamond search wins. Otherwise it is the winning 7-bit candidate index, zero-extended.
- R8: On equal SADs the diamond result beats both spread results, and the held first-half best beats the second-half best.
- R9: `dsSad` and `dsMv` are sampled at the edge where `finalValid` rises. Changes made after that edge leave the final outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| clearBest | input | 1 | Resets the held best at the start of a block |
| batchValid | input | 1 | A batch is present on the candidate inputs |
| batchSecond | input | 1 | 0 = first half, 1 = second half |
| candMask | input | 64 | Per-lane enable; clear lanes count as maximum SAD |
| candSads | input | 1024 | 64 SADs of 16 bits, lane i at bits 16*i+15:16*i |
| dsSad | input | 16 | Diamond-search best SAD |
| dsMv | input | 16 | Diamond-search motion vector |
| batchDone | output | 1 | Batch result valid |
| batchSad | output | 16 | Lowest SAD of the batch |
| batchIdx | output | 7 | {half flag, lane} of the batch winner |
| finalValid | output | 1 | Final decision valid |
| finalSad | output | 16 | SAD of the final winner |
| finalFromDiamond | output | 1 | 1 when the diamond result won |
| finalMv | output | 16 | Final motion vector or zero-extended candidate index |

## Verification
The assertions assume that `batchValid` is low while reset is asserted. This keeps the latency check from looking back at a batch that started before reset. The bench holds every input at zero during reset. It also drives inputs only on falling edges, so the values each property sees at a rising edge are stable. The final-decision checks assume that the diamond result is present on the cycle before `finalValid` rises. The bench sets `dsSad` and `dsMv` before the second half is presented, and changes them only in the test that probes that sampling edge.

// File: rtl/min_sel_pkg.sv
package min_sel_pkg;

  // Strobes from the sequencing control to the selection datapath.
  typedef struct packed {
    logic load;    // tree root is valid this cycle
    logic second;  // root belongs to the second half
    logic clear;   // reset the held best
  } sel_strobe_t;

endpackage

// File: rtl/sad_min_ctrl.sv
module sad_min_ctrl
  import min_sel_pkg::*;
#(
  parameter int LAT = 7
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        batchValid,
  input  logic        batchSecond,
  input  logic        clearBest,
  output sel_strobe_t strobe,
  output logic        batchDone,
  output logic        finalValid
);

  localparam int DEPTH = LAT - 1;

  logic [DEPTH-1:0] vldPipe;
  logic [DEPTH-1:0] secPipe;

  // Valid and half flag follow the tree levels one stage per cycle.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vldPipe <= '0;
      secPipe <= '0;
    end else begin
      vldPipe <= {vldPipe[DEPTH-2:0], batchValid};
      secPipe <= {secPipe[DEPTH-2:0], batchValid & batchSecond};
    end
  end

  always_comb begin
    strobe.load   = vldPipe[DEPTH-1];
    strobe.second = secPipe[DEPTH-1];
    strobe.clear  = clearBest;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      batchDone  <= 1'b0;
      finalValid <= 1'b0;
    end else begin
      batchDone  <= strobe.load;
      finalValid <= strobe.load & strobe.second;
    end
  end

  // R2: every completed batch was presented exactly LAT edges earlier
  a_r2_fixed_latency: assert property (@(posedge clk) disable iff (!rstN)
    batchDone |-> $past(batchValid, LAT));

  // R7: the final result appears together with a second-half batch result
  a_r7_final_with_batch: assert property (@(posedge clk) disable iff (!rstN)
    finalValid |-> (batchDone && $past(batchSecond, LAT)));

endmodule

// File: rtl/sad_min_datapath.sv
module sad_min_datapath
  import min_sel_pkg::*;
#(
  parameter int NUM_IN = 64,
  parameter int SAD_W  = 16,
  parameter int MV_W   = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  sel_strobe_t             strobe,
  input  logic [NUM_IN-1:0]       candMask,
  input  logic [NUM_IN*SAD_W-1:0] candSads,
  input  logic [SAD_W-1:0]        dsSad,
  input  logic [MV_W-1:0]         dsMv,
  output logic [SAD_W-1:0]        batchSad,
  output logic [$clog2(NUM_IN):0] batchIdx,
  output logic [SAD_W-1:0]        finalSad,
  output logic                    finalFromDiamond,
  output logic [MV_W-1:0]         finalMv
);

  localparam int LEVELS = $clog2(NUM_IN);
  localparam int LANE_W = LEVELS;
  localparam int IDX_W  = LANE_W + 1;
  localparam logic [SAD_W-1:0] SAD_MAX = {SAD_W{1'b1}};

  typedef struct packed {
    logic [SAD_W-1:0]  sad;
    logic [LANE_W-1:0] lane;
  } node_t;

  // Left operand always carries the lower lane, so it keeps ties.
  function automatic node_t pickLower(node_t left, node_t right);
    return (right.sad < left.sad) ? right : left;
  endfunction

  // Reduction tree: level 0 is the masked input, each further level is
  // one registered pairwise comparison.
  for (genvar lv = 0; lv <= LEVELS; lv++) begin : g_lvl
    localparam int W = NUM_IN >> lv;
    node_t node [W];
    if (lv == 0) begin : g_leaf
      always_comb begin
        for (int i = 0; i < W; i++) begin
          node[i].sad  = candMask[i] ? candSads[i*SAD_W +: SAD_W] : SAD_MAX;
          node[i].lane = LANE_W'(i);
        end
      end
    end else begin : g_cmp
      always_ff @(posedge clk) begin
        for (int i = 0; i < W; i++) begin
          node[i] <= pickLower(g_lvl[lv-1].node[2*i], g_lvl[lv-1].node[2*i+1]);
        end
      end
    end
  end

  node_t             root;
  logic [IDX_W-1:0]  rootIdx;
  logic [SAD_W-1:0]  heldSad;
  logic [IDX_W-1:0]  heldIdx;
  logic [SAD_W-1:0]  spreadSad;
  logic [IDX_W-1:0]  spreadIdx;
  logic              dsWins;

  always_comb begin
    root    = g_lvl[LEVELS].node[0];
    rootIdx = {strobe.second, root.lane};
    // held first-half best keeps ties against the second half
    if (root.sad < heldSad) begin
      spreadSad = root.sad;
      spreadIdx = rootIdx;
    end else begin
      spreadSad = heldSad;
      spreadIdx = heldIdx;
    end
    dsWins = (dsSad <= spreadSad);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      batchSad         <= '0;
      batchIdx         <= '0;
      heldSad          <= SAD_MAX;
      heldIdx          <= '0;
      finalSad         <= '0;
      finalFromDiamond <= 1'b0;
      finalMv          <= '0;
    end else begin
      if (strobe.load) begin
        batchSad <= root.sad;
        batchIdx <= rootIdx;
      end
      if (strobe.clear) begin
        heldSad <= SAD_MAX;
        heldIdx <= '0;
      end else if (strobe.load && !strobe.second && (root.sad < heldSad)) begin
        heldSad <= root.sad;
        heldIdx <= rootIdx;
      end
      if (strobe.load && strobe.second) begin
        finalFromDiamond <= dsWins;
        finalSad         <= dsWins ? dsSad : spreadSad;
        finalMv          <= dsWins ? dsMv : MV_W'(spreadIdx);
      end
    end
  end

  // R6: the held best never rises unless a clear was requested
  a_r6_held_no_rise: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.clear |=> (heldSad <= $past(heldSad)));

  // R6: a clear leaves the held best at the maximum value
  a_r6_clear_max: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (heldSad == SAD_MAX));

  // R7: the final SAD is never above the second-half best or the diamond SAD
  a_r7_final_bound: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.second) |=>
      ((finalSad <= batchSad) && (finalSad <= $past(dsSad))));

  // R8: a zero diamond SAD cannot lose a tie
  a_r8_diamond_tie: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.second && (dsSad == '0)) |=>
      (finalFromDiamond && (finalMv == $past(dsMv))));

endmodule

// File: rtl/min_sad_select.sv
module min_sad_select
  import min_sel_pkg::*;
#(
  parameter int NUM_IN = 64,
  parameter int SAD_W  = 16,
  parameter int MV_W   = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    clearBest,
  input  logic                    batchValid,
  input  logic                    batchSecond,
  input  logic [NUM_IN-1:0]       candMask,
  input  logic [NUM_IN*SAD_W-1:0] candSads,
  input  logic [SAD_W-1:0]        dsSad,
  input  logic [MV_W-1:0]         dsMv,
  output logic                    batchDone,
  output logic [SAD_W-1:0]        batchSad,
  output logic [$clog2(NUM_IN):0] batchIdx,
  output logic                    finalValid,
  output logic [SAD_W-1:0]        finalSad,
  output logic                    finalFromDiamond,
  output logic [MV_W-1:0]         finalMv
);

  localparam int LEVELS = $clog2(NUM_IN);
  localparam int LAT    = LEVELS + 1;

  sel_strobe_t strobe;

  sad_min_ctrl #(.LAT(LAT)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .batchValid (batchValid),
    .batchSecond(batchSecond),
    .clearBest  (clearBest),
    .strobe     (strobe),
    .batchDone  (batchDone),
    .finalValid (finalValid)
  );

  sad_min_datapath #(.NUM_IN(NUM_IN), .SAD_W(SAD_W), .MV_W(MV_W)) u_dp (
    .clk             (clk),
    .rstN            (rstN),
    .strobe          (strobe),
    .candMask        (candMask),
    .candSads        (candSads),
    .dsSad           (dsSad),
    .dsMv            (dsMv),
    .batchSad        (batchSad),
    .batchIdx        (batchIdx),
    .finalSad        (finalSad),
    .finalFromDiamond(finalFromDiamond),
    .finalMv         (finalMv)
  );

endmodule

// File: tb/test_min_sad_select.sv
module test_min_sad_select;

  localparam int NUM_IN = 64;
  localparam int SAD_W  = 16;
  localparam int MV_W   = 16;
  localparam int SMAX   = 65535;

  logic                    clk = 1'b0;
  logic                    rstN = 1'b0;
  logic                    clearBest = 1'b0;
  logic                    batchValid = 1'b0;
  logic                    batchSecond = 1'b0;
  logic [NUM_IN-1:0]       candMask = '0;
  logic [NUM_IN*SAD_W-1:0] candSads = '0;
  logic [SAD_W-1:0]        dsSad = '0;
  logic [MV_W-1:0]         dsMv = '0;
  logic                    batchDone;
  logic [SAD_W-1:0]        batchSad;
  logic [6:0]              batchIdx;
  logic                    finalValid;
  logic [SAD_W-1:0]        finalSad;
  logic                    finalFromDiamond;
  logic [MV_W-1:0]         finalMv;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  min_sad_select #(.NUM_IN(NUM_IN), .SAD_W(SAD_W), .MV_W(MV_W)) i_min_sad_select (
    .clk(clk), .rstN(rstN), .clearBest(clearBest), .batchValid(batchValid),
    .batchSecond(batchSecond), .candMask(candMask), .candSads(candSads),
    .dsSad(dsSad), .dsMv(dsMv), .batchDone(batchDone), .batchSad(batchSad),
    .batchIdx(batchIdx), .finalValid(finalValid), .finalSad(finalSad),
    .finalFromDiamond(finalFromDiamond), .finalMv(finalMv)
  );

  typedef struct packed {
    logic [6:0]  c1;
    logic [5:0]  l1;
    logic [15:0] s1;
    logic [6:0]  c2;
    logic [5:0]  l2;
    logic [15:0] s2;
    logic [15:0] ds;
    logic [15:0] mv;
  } vec_t;

  // count, winner lane, winner SAD for each half; diamond SAD and vector
  localparam vec_t VECS [8] = '{
    '{7'd48, 6'd5,  16'd100,   7'd48, 6'd40, 16'd200, 16'd500,  16'h1234},
    '{7'd48, 6'd5,  16'd300,   7'd48, 6'd17, 16'd150, 16'd500,  16'h0042},
    '{7'd64, 6'd63, 16'd50,    7'd33, 6'd32, 16'd60,  16'd40,   16'h0abc},
    '{7'd33, 6'd32, 16'd70,    7'd64, 6'd0,  16'd70,  16'd900,  16'h0001},
    '{7'd40, 6'd10, 16'd80,    7'd40, 6'd10, 16'd90,  16'd80,   16'h0777},
    '{7'd48, 6'd50, 16'd10,    7'd48, 6'd3,  16'd20,  16'd700,  16'h0002},
    '{7'd64, 6'd30, 16'd0,     7'd64, 6'd31, 16'd0,   16'd5,    16'h0003},
    '{7'd36, 6'd35, 16'hffff,  7'd36, 6'd2,  16'd999, 16'd2000, 16'h0004}
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int filler(int i);
    return 1000 + (i * 7) % 50;
  endfunction

  function automatic logic [NUM_IN*SAD_W-1:0] fillSads(int lane, int win);
    logic [NUM_IN*SAD_W-1:0] v;
    for (int i = 0; i < NUM_IN; i++)
      v[i*SAD_W +: SAD_W] = (i == lane) ? SAD_W'(win) : SAD_W'(filler(i));
    return v;
  endfunction

  function automatic logic [NUM_IN-1:0] maskOf(int cnt);
    logic [NUM_IN-1:0] m;
    for (int i = 0; i < NUM_IN; i++) m[i] = (i < cnt);
    return m;
  endfunction

  // Lowest SAD among enabled lanes, lowest lane on ties; masked = max.
  task automatic modelBest(input int cnt, input int lane, input int win,
                           output int bs, output int bl);
    bs = SMAX;
    bl = 0;
    for (int i = 0; i < cnt; i++) begin
      int s;
      s = (i == lane) ? win : filler(i);
      if (s < bs) begin
        bs = s;
        bl = i;
      end
    end
  endtask

  task automatic drive(input bit sec, input logic [NUM_IN-1:0] m,
                       input logic [NUM_IN*SAD_W-1:0] s);
    batchValid  = 1'b1;
    batchSecond = sec;
    candMask    = m;
    candSads    = s;
    @(negedge clk);
    batchValid  = 1'b0;
    batchSecond = 1'b0;
    candMask    = '0;
  endtask

  task automatic pulseClear();
    clearBest = 1'b1;
    @(negedge clk);
    clearBest = 1'b0;
  endtask

  task automatic runVector(input vec_t v);
    int b1s, b1l, b2s, b2l, hs, hi, ss, si;
    modelBest(int'(v.c1), int'(v.l1), int'(v.s1), b1s, b1l);
    modelBest(int'(v.c2), int'(v.l2), int'(v.s2), b2s, b2l);
    hs = SMAX; hi = 0;
    if (b1s < hs) begin hs = b1s; hi = b1l; end
    if (b2s < hs) begin ss = b2s; si = 64 + b2l; end
    else begin ss = hs; si = hi; end
    dsSad = v.ds;
    dsMv  = v.mv;
    pulseClear();
    drive(1'b0, maskOf(int'(v.c1)), fillSads(int'(v.l1), int'(v.s1)));
    drive(1'b1, maskOf(int'(v.c2)), fillSads(int'(v.l2), int'(v.s2)));
    repeat (4) @(negedge clk);
    check("R2 done not early", int'(batchDone), 0);
    @(negedge clk);
    check("R2 done first half", int'(batchDone), 1);
    check("R3 first sad", int'(batchSad), b1s);
    check("R3 first idx", int'(batchIdx), b1l);
    check("R7 no final on first half", int'(finalValid), 0);
    @(negedge clk);
    check("R2 done second half", int'(batchDone), 1);
    check("R3 second sad", int'(batchSad), b2s);
    check("R3 second idx", int'(batchIdx), 64 + b2l);
    check("R7 final valid", int'(finalValid), 1);
    if (int'(v.ds) <= ss) begin
      check("R8 final from diamond", int'(finalFromDiamond), 1);
      check("R7 final sad", int'(finalSad), int'(v.ds));
      check("R7 final mv", int'(finalMv), int'(v.mv));
    end else begin
      check("R8 final from spread", int'(finalFromDiamond), 0);
      check("R7 final sad", int'(finalSad), ss);
      check("R7 final mv", int'(finalMv), si);
    end
    @(negedge clk);
    check("R2 done single pulse", int'(batchDone), 0);
    check("R7 final single pulse", int'(finalValid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [NUM_IN*SAD_W-1:0] s;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 batchDone", int'(batchDone), 0);
    check("R1 finalValid", int'(finalValid), 0);
    check("R1 batchSad", int'(batchSad), 0);
    check("R1 finalSad", int'(finalSad), 0);
    check("R1 finalMv", int'(finalMv), 0);
    rstN = 1'b1;
    @(negedge clk);

    // table of vectors: R2, R3, R5, R7, R8
    for (int k = 0; k < 8; k++) runVector(VECS[k]);

    // R4: two lanes share the minimum; the lower lane is reported
    s = fillSads(7, 5);
    s[20*SAD_W +: SAD_W] = 16'd5;
    drive(1'b0, '1, s);
    repeat (6) @(negedge clk);
    check("R4 tie sad", int'(batchSad), 5);
    check("R4 tie lower lane", int'(batchIdx), 7);

    // R5: every lane masked gives maximum SAD at lane 0
    drive(1'b0, '0, fillSads(9, 3));
    repeat (6) @(negedge clk);
    check("R5 all masked sad", int'(batchSad), SMAX);
    check("R5 all masked idx", int'(batchIdx), 0);

    // R6: two first-half batches accumulate; only a strictly lower one replaces
    dsSad = 16'd900; dsMv = 16'h0055;
    pulseClear();
    drive(1'b0, '1, fillSads(3, 100));
    drive(1'b0, '1, fillSads(9, 300));
    drive(1'b1, '1, fillSads(4, 200));
    repeat (6) @(negedge clk);
    check("R6 accumulate valid", int'(finalValid), 1);
    check("R6 accumulate sad", int'(finalSad), 100);
    check("R6 accumulate mv", int'(finalMv), 3);

    // R6: clear at the same edge as a first-half load wins
    pulseClear();
    drive(1'b0, '1, fillSads(3, 50));
    repeat (5) @(negedge clk);
    clearBest = 1'b1;
    @(negedge clk);
    clearBest = 1'b0;
    check("R6 load seen with clear", int'(batchSad), 50);
    drive(1'b1, '1, fillSads(2, 400));
    repeat (6) @(negedge clk);
    check("R6 clear priority sad", int'(finalSad), 400);
    check("R6 clear priority mv", int'(finalMv), 66);
    check("R6 clear priority source", int'(finalFromDiamond), 0);

    // R9: diamond inputs sampled at the edge where finalValid rises
    dsSad = 16'd10; dsMv = 16'd11;
    pulseClear();
    drive(1'b0, '1, fillSads(1, 100));
    drive(1'b1, '1, fillSads(2, 200));
    repeat (5) @(negedge clk);
    dsSad = 16'd20; dsMv = 16'd77;
    @(negedge clk);
    check("R9 late diamond sad used", int'(finalSad), 20);
    check("R9 late diamond mv used", int'(finalMv), 77);
    dsSad = 16'd1; dsMv = 16'd99;
    @(negedge clk);
    check("R9 change after edge ignored sad", int'(finalSad), 20);
    check("R9 change after edge ignored mv", int'(finalMv), 77);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule